// File: doc/BRIEF.md
# Multi-mode accumulator instruction sequencer

This block is a compact multi-cycle core with one accumulator register. It reads variable-length instructions from an internal word-addressed memory and runs them one after another. Each instruction is two or three words long. It can add to the accumulator in four ways: with a literal operand, from a direct address, through a pointer held in memory, or from a base address plus an index read from memory. It can also jump to an absolute address or branch by a signed offset. Words carry no type; a word acts as an opcode, an address or data only by the phase in which it is fetched.

The memory has a single port with a one-cycle read latency. While reset is held, the environment loads the program through that same port. After reset is released the core fetches from address zero. Each read costs one cycle, so a direct add takes four cycles, an indirect add five and an indexed add six. A word with an unknown opcode stops the core.

Top module: `acc_seq`

## Requirements
- R1: While `rst` is high, a word on `ld_data` is written to memory at `ld_addr` when `ld_we` is high. Reset clears `acc`, `pc` and `halt` to zero. The first fetch after release is from address 0.
- R2: Opcode 41 (add-literal) adds the following word to `acc` and advances `pc` by 2. `acc` and `pc` update on the 3rd rising edge after the fetch begins.
- R3: Opcode 40 (add-direct) adds memory[word1] to `acc` and advances `pc` by 2. The update lands on the 4th edge.
- R4: Opcode 42 (add-via-pointer) adds memory[memory[word1]] to `acc` and advances `pc` by 2. The update lands on the 5th edge.
- R5: Opcode 43 (add-indexed) takes three words: opcode, base, and index location. It adds memory[(base + memory[index location]) mod 2^AW] to `acc` and advances `pc` by 3. The update lands on the 6th edge.
- R6: Opcode 70 (jump) loads `pc` with word1 on the 3rd edge. `acc` is unchanged.
- R7: Opcode 167 (relative branch) sets `pc` to (address of the offset word + 1 + offset) mod 2^AW, where the offset is two's complement. This allows backward branches. The update lands on the 3rd edge.
- R8: Any other opcode raises `halt` on the 2nd edge after its fetch begins. `halt` then stays high, and `acc` and `pc` stay frozen until reset. `pc` holds the address of the offending word.
- R9: The accumulator sum wraps modulo 2^DW.
- R10: An address taken from a memory word uses only its low AW bits. Any word may serve as opcode, address or data, depending on the phase in which it is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; enables program loading |
| ld_we | input | 1 | Load write strobe, honoured only during reset |
| ld_addr | input | AW | Load word address |
| ld_data | input | DW | Load word value |
| halt | output | 1 | Core stopped on an unknown opcode |
| acc | output | DW | Accumulator |
| pc | output | AW | Program counter |

## Verification
The bench builds the block with its default widths: 8-bit addresses, giving a 256-word memory, and 16-bit words. At these sizes a base of 250 plus an index of 10 wraps to address 4, and a branch at 250 wraps forward to 6. Both wrap cases fit in short programs, as does an accumulator overflow past 0xFFFF. A behavioural instruction-level model predicts `acc`, `pc` and `halt` on every cycle, so the cycle count of each mode is checked along with its result.

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          halt,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] pc
);
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] OP_DIR = DW'(40);
  localparam logic [DW-1:0] OP_LIT = DW'(41);
  localparam logic [DW-1:0] OP_PTR = DW'(42);
  localparam logic [DW-1:0] OP_IDX = DW'(43);
  localparam logic [DW-1:0] OP_JMP = DW'(70);
  localparam logic [DW-1:0] OP_REL = DW'(167);

  typedef enum logic [2:0] {
    S_FETCH, S_OPC, S_W1, S_W2, S_PTR, S_IDX, S_DATA, S_STOP
  } st_t;

  st_t           st;
  logic [DW-1:0] op, rdata;
  logic [AW-1:0] base, core_addr, mem_addr;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_a;

  assign rd_a     = rdata[AW-1:0];
  assign mem_addr = rst ? ld_addr : core_addr;

  always_ff @(posedge clk) begin
    if (rst && ld_we) mem[mem_addr] <= ld_data;
    rdata <= mem[mem_addr];
  end

  always_comb begin
    case (st)
      S_OPC:        core_addr = pc + AW'(1);
      S_W1:         core_addr = (op == OP_IDX) ? pc + AW'(2) : rd_a;
      S_W2, S_PTR:  core_addr = rd_a;
      S_IDX:        core_addr = base + rd_a;
      default:      core_addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_FETCH;
      acc  <= '0;
      pc   <= '0;
      halt <= 1'b0;
      op   <= '0;
      base <= '0;
    end else begin
      case (st)
        S_FETCH: st <= S_OPC;
        S_OPC: begin
          op <= rdata;
          if (rdata inside {OP_DIR, OP_LIT, OP_PTR, OP_IDX, OP_JMP, OP_REL}) begin
            st <= S_W1;
          end else begin
            st   <= S_STOP;
            halt <= 1'b1;
          end
        end
        S_W1: begin
          case (op)
            OP_LIT: begin
              acc <= acc + rdata;
              pc  <= pc + AW'(2);
              st  <= S_FETCH;
            end
            OP_DIR: st <= S_DATA;
            OP_PTR: st <= S_PTR;
            OP_IDX: begin
              base <= rd_a;
              st   <= S_W2;
            end
            OP_JMP: begin
              pc <= rd_a;
              st <= S_FETCH;
            end
            OP_REL: begin
              pc <= pc + AW'(2) + rd_a;
              st <= S_FETCH;
            end
            default: st <= S_FETCH;
          endcase
        end
        S_W2:  st <= S_IDX;
        S_PTR: st <= S_DATA;
        S_IDX: st <= S_DATA;
        S_DATA: begin
          acc <= acc + rdata;
          pc  <= pc + ((op == OP_IDX) ? AW'(3) : AW'(2));
          st  <= S_FETCH;
        end
        default: st <= S_STOP;
      endcase
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc == '0 && pc == '0 && !halt));

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(acc) && $stable(pc)));

  a_r2_lit_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_W1 && op == OP_LIT) |=> (pc == $past(pc) + AW'(2)));

  a_r5_idx_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA && op == OP_IDX) |=> (pc == $past(pc) + AW'(3)));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    (st == S_W1 && op == OP_JMP) |=> (pc == $past(rd_a) && $stable(acc)));

  a_r7_rel_target: assert property (@(posedge clk) disable iff (rst)
    (st == S_W1 && op == OP_REL) |=> (pc == $past(pc) + AW'(2) + $past(rd_a)));
endmodule

// File: tb/acc_seq_test.sv
module acc_seq_test;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic          halt;
  logic [DW-1:0] acc;
  logic [AW-1:0] pc;

  int total = 0;
  int bad = 0;
  int prog [DEPTH];
  int bm [DEPTH];
  int mpc, macc, left, npc, nacc;
  bit mhalt, nhalt, done;
  string cur_req = "R1";

  acc_seq #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .halt(halt), .acc(acc), .pc(pc)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && !mhalt) begin
      if (left == 0) begin
        int op, w1, w2;
        op = bm[mpc]; w1 = bm[(mpc + 1) % DEPTH]; w2 = bm[(mpc + 2) % DEPTH];
        nacc = macc; npc = mpc; nhalt = 1'b0;
        case (op)
          41: begin nacc = macc + w1; npc = mpc + 2; left = 3; cur_req = "R2"; end
          40: begin nacc = macc + bm[w1 % DEPTH]; npc = mpc + 2; left = 4; cur_req = "R3"; end
          42: begin nacc = macc + bm[bm[w1 % DEPTH] % DEPTH]; npc = mpc + 2; left = 5; cur_req = "R4"; end
          43: begin nacc = macc + bm[(w1 + bm[w2 % DEPTH]) % DEPTH]; npc = mpc + 3; left = 6; cur_req = "R5"; end
          70: begin npc = w1; left = 3; cur_req = "R6"; end
          167: begin npc = mpc + 2 + w1; left = 3; cur_req = "R7"; end
          default: begin nhalt = 1'b1; left = 2; cur_req = "R8"; end
        endcase
      end
      left--;
      if (left == 0) begin
        macc = nacc % (1 << DW);
        mpc = npc % DEPTH;
        mhalt = nhalt;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, int'(acc), macc, "acc per cycle");
      check(cur_req, int'(pc), mpc, "pc per cycle");
      check(cur_req, int'(halt), int'(mhalt), "halt per cycle");
    end
  end

  task automatic run_prog(input int cycles);
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(a); ld_data = DW'(prog[a]); bm[a] = prog[a];
    end
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    check("R1", int'(acc), 0, "acc in reset");
    check("R1", int'(pc), 0, "pc in reset");
    check("R1", int'(halt), 0, "halt in reset");
    mpc = 0; macc = 0; mhalt = 1'b0; left = 0; cur_req = "R1";
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int a = 0; a < DEPTH; a++) prog[a] = 0;
  endtask

  initial begin
    int held_acc;
    done = 1'b0;
    clear_prog();
    prog[0] = 41; prog[1] = 1;
    prog[2] = 40; prog[3] = 24;
    prog[4] = 42; prog[5] = 37;
    prog[6] = 43; prog[7] = 20; prog[8] = 36;
    prog[9] = 70; prog[10] = 12;
    prog[12] = 167; prog[13] = 30;
    prog[44] = 167; prog[45] = 16'hFFF0;
    prog[30] = 41; prog[31] = 16'h7FFF;
    prog[32] = 41; prog[33] = 16'h8002;
    prog[20] = 5; prog[21] = 16'hFFFE; prog[22] = 3; prog[23] = 9; prog[24] = 1;
    prog[36] = 4; prog[37] = 24;
    run_prog(80);
    check("R9", int'(acc), 5, "acc after wrap");
    check("R8", int'(pc), 34, "pc at unknown opcode");
    check("R8", int'(halt), 1, "halt raised");
    held_acc = int'(acc);
    repeat (20) @(negedge clk);
    check("R8", int'(acc), held_acc, "acc frozen while halted");
    check("R8", int'(pc), 34, "pc frozen while halted");

    clear_prog();
    prog[0] = 43; prog[1] = 250; prog[2] = 10; prog[10] = 10;
    prog[3] = 70; prog[4] = 7;
    prog[7] = 40; prog[8] = 16'h0103;
    prog[9] = 16'hFFFF;
    run_prog(40);
    check("R5", int'(acc), 77, "indexed wrap plus direct on shared word");
    check("R10", int'(pc), 9, "pc after low-bit address use");

    clear_prog();
    prog[0] = 70; prog[1] = 250;
    prog[250] = 167; prog[251] = 10;
    prog[6] = 42; prog[7] = 16'h0120;
    prog[32] = 16'h0040; prog[64] = 5;
    prog[8] = 1;
    run_prog(40);
    check("R7", int'(acc), 5, "acc after wrapped relative branch");
    check("R7", int'(pc), 8, "pc after wrapped relative branch");

    clear_prog();
    prog[0] = 41; prog[1] = 3; prog[2] = 70; prog[3] = 0;
    run_prog(60);
    check("R2", int'(halt), 0, "loop never halts");
    check("R2", int'(acc), 30, "ten loop passes");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    done = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule